// File: doc/BRIEF.md
# Floating-Point Condition and Exception Status Unit

This block keeps the condition and exception state that a floating-point unit refreshes after every result. When an operation completes, the datapath presents a four-bit classification of the result and the exceptions that operation raised. The unit stores the classification as condition flags. It replaces its per-operation exception byte with the new exceptions. It also ORs them into a sticky accrued byte that only a clear strobe empties.

A predicate test selects one of 32 relations with a five-bit code and evaluates it against the stored flags. It returns a registered true/false answer. Half of the codes are quiet and half are signalling. A signalling code that meets an unordered (NaN) operand raises the branch-on-unordered exception. That exception enters both exception bytes like any other. A trap request is raised while any exception in the per-operation byte is also enabled in the caller's enable byte.

Top module: `fpsr_status_unit`

## Requirements
- R1: While reset is low, the condition flags, the exception status byte, the accrued byte and the predicate result are all zero. The trap request is therefore low.
- R2: On a clock with `upd_valid` high, `cond_flags` loads `res_class`, where bit 3 is negative, bit 2 is zero, bit 1 is infinity and bit 0 is NaN. On any other clock the flags hold.
- R3: On a clock with `upd_valid` high, `exc_status` is replaced by that operation's exceptions. The bit order is 7 branch-on-unordered, 6 signalling NaN, 5 operand error, 4 overflow, 3 underflow, 2 divide by zero, 1 inexact result, 0 inexact decimal input. Older contents are dropped.
- R4: `accrued` ORs in every exception recorded in `exc_status` and never loses a bit except through `clr_accrued`. The clear strobe zeroes it, but exceptions arriving on the same clock are still kept.
- R5: Bits 3:0 of `pred_sel` form a mask over the relations unordered (bit 3), greater (bit 2), less (bit 1) and equal (bit 0). The predicate is true when the single relation that holds is in the mask. Unordered = NaN. Equal = Z and not NaN. Less = N and not Z and not NaN. Greater = neither N nor Z nor NaN.
- R6: `pred_true` is loaded on a clock with `pred_eval` high and holds otherwise. It is computed from the flags stored before that clock, even when `upd_valid` is high on the same clock.
- R7: When `pred_sel[4]` is 1 (signalling), `pred_eval` is high and the stored NaN flag is 1, bit 7 (branch-on-unordered) is set in both `exc_status` and `accrued`. Quiet codes (`pred_sel[4]` = 0) never set it.
- R8: A predicate test without an update replaces `exc_status` with the test's own result. That result is bit 7 alone when branch-on-unordered was raised and zero otherwise. A test together with an update records the union of both.
- R9: `trap_req` is high exactly when `exc_status & exc_enable` is nonzero.
- R10: On a NaN result, greater-or-less (code 5'b00110 or 5'b10110) is false, while not-equal (5'b01110) is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | A result is complete this clock |
| res_class | input | 4 | Result classification {N, Z, I, NaN} |
| op_exc | input | 8 | Exceptions raised by the completing operation |
| exc_enable | input | 8 | Per-exception trap enable |
| pred_eval | input | 1 | Evaluate the selected predicate this clock |
| pred_sel | input | 5 | Predicate code: bit 4 signalling, bits 3:0 relation mask |
| clr_accrued | input | 1 | Zero the accrued byte |
| cond_flags | output | 4 | Stored condition flags |
| exc_status | output | 8 | Exceptions of the most recent operation |
| accrued | output | 8 | Sticky exceptions since the last clear |
| pred_true | output | 1 | Result of the last predicate test |
| trap_req | output | 1 | An enabled exception is pending |

## Verification
The assertions watch properties that hold on every clock:
- flags hold between updates;
- the status byte copies the update's exceptions;
- accrued bits never drop without a clear;
- branch-on-unordered appears after a signalling test on NaN and never after a quiet one;
- the predicate result holds between tests;
- no trap is raised with an empty status byte.

The truth value of each of the 32 codes over every relation can only be shown by the bench's scenarios. The same goes for the greater-or-less versus not-equal split on NaN, the same-clock clear-and-raise case, and a test that lands on the same clock as an update.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
   // positions of the stored condition flags
   localparam int unsigned FLAG_W   = 4;
   localparam int unsigned FLAG_NEG = 3;
   localparam int unsigned FLAG_ZER = 2;
   localparam int unsigned FLAG_INF = 1;
   localparam int unsigned FLAG_NAN = 0;

   // one-hot relation vector, bit order matches the predicate mask
   typedef struct packed {
      logic unord;
      logic gt;
      logic lt;
      logic eq;
   } rel_t;

   localparam int unsigned REL_W = $bits(rel_t);
endpackage

// File: rtl/fpsr_rel_decode.sv
module fpsr_rel_decode
   import fpsr_pkg::*;
(
   input  logic neg,
   input  logic zer,
   input  logic nan,
   output rel_t rel
);
   always_comb begin
      rel.unord = nan;
      rel.eq    = zer & ~nan;
      rel.lt    = neg & ~zer & ~nan;
      rel.gt    = ~neg & ~zer & ~nan;
   end
endmodule

// File: rtl/fpsr_pred_eval.sv
module fpsr_pred_eval
   import fpsr_pkg::*;
#(
   parameter int unsigned SEL_W = 5
) (
   input  logic [SEL_W-1:0] sel,
   input  rel_t             rel,
   input  logic             test,
   output logic             hit,
   output logic             bsun
);
   localparam int unsigned SIG_BIT = SEL_W - 1;

   logic [REL_W-1:0] mask;
   assign mask = sel[REL_W-1:0];
   assign hit  = |(mask & rel);
   assign bsun = test & sel[SIG_BIT] & rel.unord;
endmodule

// File: rtl/fpsr_exc_track.sv
module fpsr_exc_track #(
   parameter int unsigned EXC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [EXC_W-1:0] op_exc,
   input  logic             test,
   input  logic             bsun,
   input  logic             clr,
   input  logic [EXC_W-1:0] enable,
   output logic [EXC_W-1:0] status,
   output logic [EXC_W-1:0] accrued,
   output logic             trap
);
   localparam int unsigned BSUN_POS = EXC_W - 1;

   logic [EXC_W-1:0] new_exc;
   logic [EXC_W-1:0] bsun_vec;

   always_comb begin
      bsun_vec           = '0;
      bsun_vec[BSUN_POS] = bsun;
      new_exc            = (upd ? op_exc : '0) | bsun_vec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status  <= '0;
         accrued <= '0;
      end else begin
         if (upd | test) status <= new_exc;
         accrued <= (clr ? '0 : accrued) | new_exc;
      end
   end

   assign trap = |(status & enable);
endmodule

// File: rtl/fpsr_status_unit.sv
module fpsr_status_unit
   import fpsr_pkg::*;
#(
   parameter int unsigned EXC_W    = 8,
   parameter int unsigned SEL_W    = 5,
   parameter bit          PRED_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  logic [3:0]        res_class,
   input  logic [EXC_W-1:0]  op_exc,
   input  logic [EXC_W-1:0]  exc_enable,
   input  logic              pred_eval,
   input  logic [SEL_W-1:0]  pred_sel,
   input  logic              clr_accrued,
   output logic [3:0]        cond_flags,
   output logic [EXC_W-1:0]  exc_status,
   output logic [EXC_W-1:0]  accrued,
   output logic              pred_true,
   output logic              trap_req
);
   generate
      if (SEL_W != REL_W + 1) begin : g_bad_sel
         $error("SEL_W must be one signalling bit plus the relation mask");
      end
      if (EXC_W < 2) begin : g_bad_exc
         $error("EXC_W too small to hold branch-on-unordered");
      end
   endgenerate

   logic [FLAG_W-1:0] flags_q;
   rel_t              rel;
   logic              hit;
   logic              bsun;

   always_ff @(posedge clk) begin
      if (!rst_n)         flags_q <= '0;
      else if (upd_valid) flags_q <= res_class;
   end

   fpsr_rel_decode u_rel (
      .neg (flags_q[FLAG_NEG]),
      .zer (flags_q[FLAG_ZER]),
      .nan (flags_q[FLAG_NAN]),
      .rel (rel)
   );

   fpsr_pred_eval #(.SEL_W(SEL_W)) u_pred (
      .sel  (pred_sel),
      .rel  (rel),
      .test (pred_eval),
      .hit  (hit),
      .bsun (bsun)
   );

   fpsr_exc_track #(.EXC_W(EXC_W)) u_exc (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (upd_valid),
      .op_exc  (op_exc),
      .test    (pred_eval),
      .bsun    (bsun),
      .clr     (clr_accrued),
      .enable  (exc_enable),
      .status  (exc_status),
      .accrued (accrued),
      .trap    (trap_req)
   );

   generate
      if (PRED_REG) begin : g_pred_reg
         logic pred_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         pred_q <= 1'b0;
            else if (pred_eval) pred_q <= hit;
         end
         assign pred_true = pred_q;
      end else begin : g_pred_comb
         assign pred_true = hit;
      end
   endgenerate

   assign cond_flags = flags_q;
endmodule

// File: rtl/fpsr_status_unit_chk.sv
module fpsr_status_unit_chk #(
   parameter int unsigned EXC_W    = 8,
   parameter int unsigned SEL_W    = 5,
   parameter bit          PRED_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             upd_valid,
   input logic [EXC_W-1:0] op_exc,
   input logic             pred_eval,
   input logic [SEL_W-1:0] pred_sel,
   input logic             clr_accrued,
   input logic [3:0]       cond_flags,
   input logic [EXC_W-1:0] exc_status,
   input logic [EXC_W-1:0] accrued,
   input logic             pred_true,
   input logic             trap_req
);
   a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(cond_flags));

   a_r3_status_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !pred_eval) |=> exc_status == $past(op_exc));

   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_accrued |=> ((accrued & $past(accrued)) == $past(accrued)));

   a_r7_bsun_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_eval && pred_sel[SEL_W-1] && cond_flags[0])
      |=> (exc_status[EXC_W-1] && accrued[EXC_W-1]));

   a_r7_quiet_no_bsun: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_eval && !pred_sel[SEL_W-1] && !upd_valid) |=> !exc_status[EXC_W-1]);

   a_r9_no_trap_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_status == '0) |-> !trap_req);

   generate
      if (PRED_REG) begin : g_hold
         a_r6_pred_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !pred_eval |=> $stable(pred_true));
      end
   endgenerate
endmodule

bind fpsr_status_unit fpsr_status_unit_chk #(
   .EXC_W(EXC_W), .SEL_W(SEL_W), .PRED_REG(PRED_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .upd_valid   (upd_valid),
   .op_exc      (op_exc),
   .pred_eval   (pred_eval),
   .pred_sel    (pred_sel),
   .clr_accrued (clr_accrued),
   .cond_flags  (cond_flags),
   .exc_status  (exc_status),
   .accrued     (accrued),
   .pred_true   (pred_true),
   .trap_req    (trap_req)
);

// File: tb/fpsr_status_unit_tb.sv
module fpsr_status_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       upd_valid;
   logic [3:0] res_class;
   logic [7:0] op_exc;
   logic [7:0] exc_enable;
   logic       pred_eval;
   logic [4:0] pred_sel;
   logic       clr_accrued;
   logic [3:0] cond_flags;
   logic [7:0] exc_status;
   logic [7:0] accrued;
   logic       pred_true;
   logic       trap_req;

   int n_chk  = 0;
   int n_fail = 0;

   logic [3:0] e_cond;
   logic [7:0] e_stat;
   logic [7:0] e_acc;
   logic       e_pred;

   always #2.5 clk = ~clk;

   fpsr_status_unit u_dut (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .res_class(res_class),
      .op_exc(op_exc), .exc_enable(exc_enable), .pred_eval(pred_eval),
      .pred_sel(pred_sel), .clr_accrued(clr_accrued), .cond_flags(cond_flags),
      .exc_status(exc_status), .accrued(accrued), .pred_true(pred_true),
      .trap_req(trap_req)
   );

   // relation vector {unord, gt, lt, eq} from flags {N,Z,I,NaN}
   function automatic logic [3:0] rel_of(input logic [3:0] f);
      if (f[0])      return 4'b1000;
      else if (f[2]) return 4'b0001;
      else if (f[3]) return 4'b0010;
      else           return 4'b0100;
   endfunction

   function automatic logic pred_of(input logic [4:0] s, input logic [3:0] f);
      return |(s[3:0] & rel_of(f));
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R2 cond_flags", {4'b0, cond_flags}, {4'b0, e_cond});
      chk("R3/R8 exc_status", exc_status, e_stat);
      chk("R4 accrued", accrued, e_acc);
      chk("R5/R6 pred_true", {7'b0, pred_true}, {7'b0, e_pred});
      chk("R9 trap_req", {7'b0, trap_req}, {7'b0, |(e_stat & exc_enable)});
   endtask

   // apply one clock of stimulus and update the model
   task automatic step(input logic u, input logic [3:0] cls, input logic [7:0] ex,
                       input logic [7:0] en, input logic pe, input logic [4:0] sel,
                       input logic clr);
      logic [7:0] nw;
      @(negedge clk);
      upd_valid = u; res_class = cls; op_exc = ex; exc_enable = en;
      pred_eval = pe; pred_sel = sel; clr_accrued = clr;
      nw = (u ? ex : 8'h00) | ((pe && sel[4] && e_cond[0]) ? 8'h80 : 8'h00);
      if (pe) e_pred = pred_of(sel, e_cond);
      if (u || pe) e_stat = nw;
      e_acc = (clr ? 8'h00 : e_acc) | nw;
      if (u) e_cond = cls;
      @(posedge clk);
      #1;
      check_all();
   endtask

   initial begin
      #100us;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [3:0] classes [4];
      void'($urandom(32'd20240917));
      classes[0] = 4'b0000; classes[1] = 4'b0100;
      classes[2] = 4'b1000; classes[3] = 4'b0001;
      rst_n = 1'b0; upd_valid = 0; res_class = 0; op_exc = 0; exc_enable = 0;
      pred_eval = 0; pred_sel = 0; clr_accrued = 0;
      e_cond = 0; e_stat = 0; e_acc = 0; e_pred = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check_all();
      @(negedge clk);
      rst_n = 1'b1;

      // R5 R7 R8: every code over every relation class
      for (int c = 0; c < 4; c++) begin
         step(1, classes[c], 8'h00, 8'hFF, 0, 5'd0, 0);
         for (int s = 0; s < 32; s++) step(0, 4'h0, 8'h00, 8'hFF, 1, 5'(s), 0);
      end

      // R10: NaN splits greater-or-less from not-equal
      step(1, 4'b0001, 8'h00, 8'h00, 0, 5'd0, 0);
      step(0, 4'h0, 8'h00, 8'h00, 1, 5'b00110, 0);
      chk("R10 GL on NaN", {7'b0, pred_true}, 8'h00);
      step(0, 4'h0, 8'h00, 8'h00, 1, 5'b01110, 0);
      chk("R10 NE on NaN", {7'b0, pred_true}, 8'h01);

      // R4: clear together with new exceptions keeps the new ones
      step(1, 4'b0000, 8'h14, 8'h00, 0, 5'd0, 0);
      step(1, 4'b0000, 8'h02, 8'h00, 0, 5'd0, 1);
      chk("R4 clear keeps same-clock", accrued, 8'h02);

      // R6: test and update on the same clock use the older flags
      step(1, 4'b1000, 8'h00, 8'h00, 0, 5'd0, 0);
      step(1, 4'b0001, 8'h00, 8'h00, 1, 5'b00010, 0);
      chk("R6 old flags used", {7'b0, pred_true}, 8'h01);

      // R9: trap follows enable directly
      step(1, 4'b0000, 8'h04, 8'h00, 0, 5'd0, 0);
      step(0, 4'h0, 8'h00, 8'h04, 0, 5'd0, 0);
      chk("R9 enabled trap", {7'b0, trap_req}, 8'h01);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0], 4'($urandom), 8'($urandom), 8'($urandom),
              r[1], 5'($urandom), r[4:2] == 3'b000);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule